// File: doc/BRIEF.md
# Shift, Rotate and Bit-Test Unit

This unit carries out the bit-manipulation group of an 8-bit processor datapath. It takes one operand byte and the current flag byte. It then returns the processed byte, the new flag byte and a write indication. All operations finish in one pass with one register stage at the output.

The unit has five operation groups:
- **Full shift/rotate group.** Eight shift and rotate kinds.
- **Accumulator rotate group.** A cheaper set of four rotates that leave most flags alone.
- **Bit test.** Tests one bit of the operand.
- **Bit clear.** Clears one bit of the operand.
- **Bit set.** Sets one bit of the operand.

The bit number is a 3-bit field. For bit tests on a memory operand, the caller supplies a hidden byte, and two undocumented flag bits are copied from it.

A request is presented with `valid_i` high. Its result appears on the outputs after the next rising clock edge, qualified by `valid_o`. The register file, memory and decimal nibble rotates are handled elsewhere.

Top module: `sru_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first request, `valid_o`, `wr_en_o`, `result_o` and `flags_o` are all 0.
- R2: A request with `valid_i`=1 shows its outputs with `valid_o`=1 exactly one rising edge later. In a cycle with `valid_i`=0, `valid_o` goes to 0 and `result_o` keeps its last value.
- R3: Rotate codes on `op_i` (group 0, or group 1 using `op_i[1:0]` only):
  - 000: rotate left, old bit 7 goes to both bit 0 and carry.
  - 001: rotate right, old bit 0 goes to both bit 7 and carry.
  - 010: rotate left through carry, incoming carry (`flags_i[0]`) goes to bit 0 and old bit 7 goes to carry.
  - 011: rotate right through carry, incoming carry goes to bit 7 and old bit 0 goes to carry.
- R4: Shift codes in group 0:
  - 100: shift left, bit 0 is filled with 0 and old bit 7 goes to carry.
  - 101: shift right, bit 7 is kept and old bit 0 goes to carry.
  - 111: shift right, bit 7 is filled with 0 and old bit 0 goes to carry.
- R5: Code 110 in group 0 shifts left, fills bit 0 with 1 and puts old bit 7 in carry.
- R6: Group 0 flags are written with flag byte bits S=7, Z=6, F5=5, H=4, F3=3, P=2, N=1, C=0:
  - S = result bit 7.
  - Z = 1 when the result is zero.
  - F5 and F3 = result bits 5 and 3.
  - H = 0 and N = 0.
  - P = 1 when the result has even parity.
  - C = the bit shifted out.
- R7: Group 1 (accumulator rotate) writes only F5 and F3 (from the result), C (the bit shifted out), and H and N (both cleared). S, Z and P keep their `flags_i` values.
- R8: Group 2 (bit test) sets Z and P to the inverse of operand bit `bit_i`. It sets H=1, clears N and keeps C.
- R9: In group 2, S=1 only when `bit_i`=7 and operand bit 7 is 1. Otherwise S=0.
- R10: In group 2, F5 and F3 come from operand bits 5 and 3 when `mem_i`=0, and from `hidden_i` bits 5 and 3 when `mem_i`=1.
- R11: Group 3 clears operand bit `bit_i` and group 4 sets it. Both pass `flags_i` through unchanged.
- R12: `wr_en_o` is 1 for groups 0, 1, 3 and 4. It is 0 for group 2 and for the unused group codes 5 to 7. For those codes, `result_o` equals the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present |
| group_i | input | 3 | Operation group (0 shift, 1 accumulator rotate, 2 test, 3 clear, 4 set) |
| op_i | input | 3 | Shift/rotate kind |
| bit_i | input | 3 | Bit number for test, clear and set |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flag byte |
| mem_i | input | 1 | Bit test on a memory operand |
| hidden_i | input | 8 | Hidden byte supplying F5/F3 for memory bit tests |
| valid_o | output | 1 | Result present |
| wr_en_o | output | 1 | Result should be written back |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |

## Verification
Two pairs of functions can land in the same output cycle.

The first pair is a bit test on bit 7 with that bit set. This drives the sign rule and the zero/parity rule together in one flag byte. The bench provokes it with operands 0x80 and 0xA5 at bit number 7, and judges S, Z and P against one expected byte.

The second pair is an accumulator rotate, where kept flags and newly written flags share the same output byte. The bench provokes it with all-ones and all-zeros incoming flags. It then checks that S, Z and P follow `flags_i` while C and F5/F3 follow the rotate.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int DW = 8;
  localparam int BW = $clog2(DW);
  localparam int GW = 3;

  localparam logic [GW-1:0] GRP_SHIFT = 3'd0;
  localparam logic [GW-1:0] GRP_ACC   = 3'd1;
  localparam logic [GW-1:0] GRP_TEST  = 3'd2;
  localparam logic [GW-1:0] GRP_CLR   = 3'd3;
  localparam logic [GW-1:0] GRP_SET   = 3'd4;

  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_5  = 5;
  localparam int F_H  = 4;
  localparam int F_3  = 3;
  localparam int F_P  = 2;
  localparam int F_N  = 1;
  localparam int F_C  = 0;

  typedef enum logic [2:0] {
    OP_RLC = 3'd0, OP_RRC = 3'd1, OP_RL  = 3'd2, OP_RR  = 3'd3,
    OP_SLA = 3'd4, OP_SRA = 3'd5, OP_SLF = 3'd6, OP_SRL = 3'd7
  } shift_op_e;
endpackage

// File: rtl/sru_rotator.sv
module sru_rotator
  import sru_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] data_i,
  input  logic [2:0]   op_i,
  input  logic         carry_i,
  output logic [W-1:0] data_o,
  output logic         carry_o
);
  logic msb, lsb;
  assign msb = data_i[W-1];
  assign lsb = data_i[0];

  always_comb begin
    unique case (shift_op_e'(op_i))
      OP_RLC: begin data_o = {data_i[W-2:0], msb};     carry_o = msb; end
      OP_RRC: begin data_o = {lsb, data_i[W-1:1]};     carry_o = lsb; end
      OP_RL:  begin data_o = {data_i[W-2:0], carry_i}; carry_o = msb; end
      OP_RR:  begin data_o = {carry_i, data_i[W-1:1]}; carry_o = lsb; end
      OP_SLA: begin data_o = {data_i[W-2:0], 1'b0};    carry_o = msb; end
      OP_SRA: begin data_o = {msb, data_i[W-1:1]};     carry_o = lsb; end
      OP_SLF: begin data_o = {data_i[W-2:0], 1'b1};    carry_o = msb; end
      default: begin data_o = {1'b0, data_i[W-1:1]};   carry_o = lsb; end
    endcase
  end
endmodule

// File: rtl/sru_bitop.sv
module sru_bitop
  import sru_pkg::*;
#(
  parameter int W  = DW,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] sel_i,
  output logic          tested_o,
  output logic [W-1:0]  cleared_o,
  output logic [W-1:0]  set_o
);
  logic [W-1:0] mask;

  for (genvar g = 0; g < W; g++) begin : g_dec
    assign mask[g] = (sel_i == SW'(g));
  end

  assign tested_o  = |(data_i & mask);
  assign cleared_o = data_i & ~mask;
  assign set_o     = data_i | mask;
endmodule

// File: rtl/sru_flags.sv
module sru_flags
  import sru_pkg::*;
(
  input  logic [GW-1:0] group_i,
  input  logic [BW-1:0] bit_i,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] rot_i,
  input  logic          rot_carry_i,
  input  logic          tested_i,
  input  logic [DW-1:0] f53_src_i,
  output logic [DW-1:0] flags_o
);
  always_comb begin
    flags_o = flags_i;
    unique case (group_i)
      GRP_SHIFT: begin
        flags_o[F_S] = rot_i[DW-1];
        flags_o[F_Z] = (rot_i == '0);
        flags_o[F_5] = rot_i[5];
        flags_o[F_H] = 1'b0;
        flags_o[F_3] = rot_i[3];
        flags_o[F_P] = ~^rot_i;
        flags_o[F_N] = 1'b0;
        flags_o[F_C] = rot_carry_i;
      end
      GRP_ACC: begin
        flags_o[F_5] = rot_i[5];
        flags_o[F_H] = 1'b0;
        flags_o[F_3] = rot_i[3];
        flags_o[F_N] = 1'b0;
        flags_o[F_C] = rot_carry_i;
      end
      GRP_TEST: begin
        flags_o[F_S] = tested_i && (bit_i == BW'(DW-1));
        flags_o[F_Z] = ~tested_i;
        flags_o[F_5] = f53_src_i[5];
        flags_o[F_H] = 1'b1;
        flags_o[F_3] = f53_src_i[3];
        flags_o[F_P] = ~tested_i;
        flags_o[F_N] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sru_top.sv
module sru_top
  import sru_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [GW-1:0] group_i,
  input  logic [2:0]    op_i,
  input  logic [BW-1:0] bit_i,
  input  logic [DW-1:0] operand_i,
  input  logic [DW-1:0] flags_i,
  input  logic          mem_i,
  input  logic [DW-1:0] hidden_i,
  output logic          valid_o,
  output logic          wr_en_o,
  output logic [DW-1:0] result_o,
  output logic [DW-1:0] flags_o
);
  logic [2:0]    rot_op;
  logic [DW-1:0] rot_res, clr_res, set_res, res_d, flags_d, f53_src;
  logic          rot_c, tested, wr_d;

  // accumulator rotates use only the low two op bits
  assign rot_op  = (group_i == GRP_ACC) ? {1'b0, op_i[1:0]} : op_i;
  assign f53_src = mem_i ? hidden_i : operand_i;

  sru_rotator #(.W(DW)) u_rot (
    .data_i(operand_i), .op_i(rot_op), .carry_i(flags_i[F_C]),
    .data_o(rot_res), .carry_o(rot_c)
  );

  sru_bitop #(.W(DW), .SW(BW)) u_bit (
    .data_i(operand_i), .sel_i(bit_i), .tested_o(tested),
    .cleared_o(clr_res), .set_o(set_res)
  );

  sru_flags u_flg (
    .group_i(group_i), .bit_i(bit_i), .flags_i(flags_i),
    .rot_i(rot_res), .rot_carry_i(rot_c), .tested_i(tested),
    .f53_src_i(f53_src), .flags_o(flags_d)
  );

  always_comb begin
    res_d = operand_i;
    wr_d  = 1'b0;
    unique case (group_i)
      GRP_SHIFT, GRP_ACC: begin res_d = rot_res; wr_d = 1'b1; end
      GRP_CLR:            begin res_d = clr_res; wr_d = 1'b1; end
      GRP_SET:            begin res_d = set_res; wr_d = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        wr_en_o  <= wr_d;
        result_o <= res_d;
        flags_o  <= flags_d;
      end
    end
  end

  // R12: bit test never requests a write
  assert_test_no_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && group_i == GRP_TEST |=> !wr_en_o);

  // R11: clear/set leave flags as presented
  assert_bitmod_flags_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (group_i == GRP_CLR || group_i == GRP_SET) |=> flags_o == $past(flags_i));

  // R7: accumulator rotate keeps S, Z, P
  assert_acc_keeps_szp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && group_i == GRP_ACC |=>
      {flags_o[F_S], flags_o[F_Z], flags_o[F_P]} ==
      {$past(flags_i[F_S]), $past(flags_i[F_Z]), $past(flags_i[F_P])});

  // R5: fill-one shift always leaves bit 0 set and carries old msb
  assert_fill_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && group_i == GRP_SHIFT && op_i == 3'd6 |=>
      result_o[0] && flags_o[F_C] == $past(operand_i[DW-1]));

  // R8: bit test Z and P agree, H set
  assert_test_zp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && group_i == GRP_TEST |=>
      flags_o[F_Z] == flags_o[F_P] && flags_o[F_H] && result_o == $past(operand_i));

  // R2: output valid follows input valid by one edge
  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: tb/sru_top_tb.sv
`timescale 1ns/1ps
module sru_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] group_i = '0, op_i = '0, bit_i = '0;
  logic [7:0] operand_i = '0, flags_i = '0, hidden_i = '0;
  logic       mem_i = 1'b0;
  logic       valid_o, wr_en_o;
  logic [7:0] result_o, flags_o;

  int n_checks = 0, n_fail = 0, n_pushed = 0, n_popped = 0;
  bit done = 1'b0;
  logic [7:0] last_res = '0;

  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    logic       wr;
    string      rtag;
    string      ftag;
  } item_t;
  item_t sb[$];

  always #4 clk_i = ~clk_i;

  sru_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .group_i(group_i),
    .op_i(op_i), .bit_i(bit_i), .operand_i(operand_i), .flags_i(flags_i),
    .mem_i(mem_i), .hidden_i(hidden_i), .valid_o(valid_o), .wr_en_o(wr_en_o),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic item_t model(input logic [2:0] g, input logic [2:0] o, input logic [2:0] b,
                                  input logic [7:0] d, input logic [7:0] fi,
                                  input logic m, input logic [7:0] h);
    item_t it;
    logic [7:0] r;
    logic co, t;
    logic [2:0] oo;
    logic [7:0] src;
    it.res = d; it.flg = fi; it.wr = 1'b0; it.rtag = "R12"; it.ftag = "R12";
    oo = (g == 3'd1) ? {1'b0, o[1:0]} : o;
    case (oo)
      3'd0: begin r = {d[6:0], d[7]}; co = d[7]; end
      3'd1: begin r = {d[0], d[7:1]}; co = d[0]; end
      3'd2: begin r = {d[6:0], fi[0]}; co = d[7]; end
      3'd3: begin r = {fi[0], d[7:1]}; co = d[0]; end
      3'd4: begin r = {d[6:0], 1'b0}; co = d[7]; end
      3'd5: begin r = {d[7], d[7:1]}; co = d[0]; end
      3'd6: begin r = {d[6:0], 1'b1}; co = d[7]; end
      default: begin r = {1'b0, d[7:1]}; co = d[0]; end
    endcase
    t = d[b];
    src = m ? h : d;
    case (g)
      3'd0: begin
        it.res = r; it.wr = 1'b1;
        it.rtag = (oo < 3'd4) ? "R3" : (oo == 3'd6) ? "R5" : "R4";
        it.flg = {r[7], r == 8'h00, r[5], 1'b0, r[3], ~^r, 1'b0, co};
        it.ftag = "R6";
      end
      3'd1: begin
        it.res = r; it.wr = 1'b1; it.rtag = "R3";
        it.flg = {fi[7], fi[6], r[5], 1'b0, r[3], fi[2], 1'b0, co};
        it.ftag = "R7";
      end
      3'd2: begin
        it.flg = {(b == 3'd7) && t, ~t, src[5], 1'b1, src[3], ~t, 1'b0, fi[0]};
        it.ftag = (b == 3'd7) ? "R9" : m ? "R10" : "R8";
      end
      3'd3: begin it.res = d & ~(8'h01 << b); it.wr = 1'b1; it.rtag = "R11"; it.ftag = "R11"; end
      3'd4: begin it.res = d | (8'h01 << b);  it.wr = 1'b1; it.rtag = "R11"; it.ftag = "R11"; end
      default: ;
    endcase
    return it;
  endfunction

  task automatic issue(input logic [2:0] g, input logic [2:0] o, input logic [2:0] b,
                       input logic [7:0] d, input logic [7:0] fi,
                       input logic m, input logic [7:0] h);
    @(negedge clk_i);
    valid_i = 1'b1; group_i = g; op_i = o; bit_i = b;
    operand_i = d; flags_i = fi; mem_i = m; hidden_i = h;
    sb.push_back(model(g, o, b, d, fi, m, h));
    n_pushed++;
  endtask

  // monitor
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && valid_o) begin
      item_t e;
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected valid", 8'(valid_o), 8'h00);
      end else begin
        e = sb.pop_front();
        n_popped++;
        check(result_o === e.res, e.rtag, result_o, e.res);
        check(flags_o === e.flg, e.ftag, flags_o, e.flg);
        check(wr_en_o === e.wr, "R12 wr_en", 8'(wr_en_o), 8'(e.wr));
        last_res = result_o;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_popped, n_pushed);
    finish_run();
  end

  initial begin
    logic [7:0] pats [5];
    pats = '{8'h81, 8'h00, 8'h80, 8'h01, 8'h5A};
    repeat (3) @(negedge clk_i);
    // R1: outputs cleared during reset
    check(valid_o === 1'b0 && wr_en_o === 1'b0, "R1 ctrl", {6'd0, valid_o, wr_en_o}, 8'h00);
    check(result_o === 8'h00 && flags_o === 8'h00, "R1 data", result_o | flags_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check(valid_o === 1'b0 && result_o === 8'h00 && flags_o === 8'h00, "R1 after release",
          result_o, 8'h00);

    // R3 R4 R5 R6: full group, all kinds, both carry-ins
    for (int o = 0; o < 8; o++)
      for (int p = 0; p < 5; p++)
        for (int c = 0; c < 2; c++)
          issue(3'd0, 3'(o), 3'd0, pats[p], c ? 8'h01 : 8'hFE, 1'b0, 8'h00);

    // R7: accumulator rotates with all-ones and all-zeros flags, op bit 2 ignored
    for (int o = 0; o < 8; o++)
      for (int p = 0; p < 5; p++) begin
        issue(3'd1, 3'(o), 3'd0, pats[p], 8'hFF, 1'b0, 8'h00);
        issue(3'd1, 3'(o), 3'd0, pats[p], 8'h00, 1'b0, 8'h00);
      end

    // R8 R9 R10: bit test, register and memory forms; bit 7 cases included
    for (int b = 0; b < 8; b++) begin
      issue(3'd2, 3'd0, 3'(b), 8'hA5, 8'h00, 1'b0, 8'h00);
      issue(3'd2, 3'd0, 3'(b), 8'h5A, 8'hFF, 1'b0, 8'h00);
      issue(3'd2, 3'd0, 3'(b), 8'h80, 8'h01, 1'b1, 8'h28);
      issue(3'd2, 3'd0, 3'(b), 8'hFF, 8'h00, 1'b1, 8'h00);
    end

    // R11: clear and set
    for (int b = 0; b < 8; b++) begin
      issue(3'd3, 3'd5, 3'(b), 8'hFF, 8'hC3, 1'b0, 8'h00);
      issue(3'd4, 3'd2, 3'(b), 8'h00, 8'h3C, 1'b0, 8'h00);
      issue(3'd3, 3'd0, 3'(b), 8'h00, 8'h55, 1'b0, 8'h00);
    end

    // R12: unused group codes
    for (int g = 5; g < 8; g++) issue(3'(g), 3'd0, 3'd3, 8'h9C, 8'hA1, 1'b0, 8'h00);

    // R2: drop valid, change inputs, result must hold
    @(negedge clk_i);
    valid_i = 1'b0; operand_i = 8'h33; group_i = 3'd0;
    @(negedge clk_i); #2;
    check(valid_o === 1'b0, "R2 valid drop", 8'(valid_o), 8'h00);
    check(result_o === last_res, "R2 hold", result_o, last_res);
    check(n_popped == n_pushed && sb.size() == 0, "R2 all delivered", 8'(n_popped), 8'(n_pushed));
    finish_run();
  end
endmodule